// File: doc/BRIEF.md
# Dual-Rounding Iterative Integer Divider

This block divides a dividend by a divisor and returns a quotient and a remainder together. Each operand has its own width parameter and its own signedness input. A signed operand is read as two's complement. An unsigned operand is read as a plain binary magnitude. One datapath serves two rounding conventions, chosen per operation by `floor_mode`. When it is low, the quotient rounds toward zero and the remainder follows the dividend's sign, as in the hardware-description `/` and `%` operators. When it is high, the quotient rounds toward negative infinity and the remainder follows the divisor's sign, as in the `%` of common scripting languages.

The unit is started with a single-cycle `start` while it is idle. It first takes operand magnitudes. It then runs one restoring subtract per dividend bit. A final cycle applies the signs and, in flooring mode, a one-step correction. `done` then pulses, and the results stay on the outputs until the next operation finishes. A zero divisor does not stall the unit. The operation completes with the same timing and raises `div_zero`.

Top module: `dualround_divider`

## Requirements
- R1: With `floor_mode`=0, the quotient is the exact quotient rounded toward zero, and the remainder is zero or has the sign of the dividend (for example 7 / -2 gives -3 remainder 1).
- R2: With `floor_mode`=1, the quotient is the exact quotient rounded toward negative infinity, and the remainder is zero or has the sign of the divisor, so that quotient*divisor + remainder equals the dividend.
- R3: -10 by 3 gives -3/-1 truncating and -4/2 flooring. 10 by -3 gives -3/1 truncating and -4/-2 flooring. -10 by -3 gives 3/-1 in both modes. 10 by 3 gives 3/1 in both modes.
- R4: `dvd_signed`=1 reads `dividend` as two's complement and `dvd_signed`=0 reads it as unsigned; `dvs_signed` does the same for `divisor`. Results are RES_W-bit two's complement.
- R5: A zero divisor completes normally with `div_zero`=1, a quotient of all ones, and a remainder equal to the dividend extended to RES_W bits under its signedness. For any other divisor, `div_zero` is 0 with `done`.
- R6: `start` is taken only while `busy` is 0. A `start` pulse while busy changes neither the running operation nor its results.
- R7: If `start` is taken at clock edge k, `busy` is 1 from edge k+1 and falls at edge k+DVD_W+1. At that same edge `done` rises, and it stays high for exactly one cycle.
- R8: After reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all 0. Outputs change only at the edge that raises `done`.
- R9: The most negative signed dividend divided by signed -1 gives the positive value 2^(DVD_W-1) with remainder 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| floor_mode | input | 1 | 0 truncating, 1 flooring |
| dvd_signed | input | 1 | Dividend is two's complement |
| dvs_signed | input | 1 | Divisor is two's complement |
| dividend | input | DVD_W | Dividend operand |
| divisor | input | DVS_W | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Completed operation had a zero divisor |
| quotient | output | RES_W | Signed quotient |
| remainder | output | RES_W | Signed remainder |

## Verification
The checker assumes that the operands, signedness inputs and mode are steady only in the cycle where `start` is taken. It captures them there and does not rely on them afterwards. It also assumes that reset is not applied in the middle of an operation. The stimulus changes inputs only on falling edges and holds `start` for one cycle. It deliberately pulses `start` during a busy period and launches an operation in the very cycle `done` is high, so the idle-only acceptance is exercised at both of its boundaries.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         is_signed,
    output logic         neg,
    output logic [W-1:0] mag
);
    always_comb begin
        neg = is_signed & val[W-1];
        mag = neg ? (~val + W'(1)) : val;
    end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
    parameter int QW = 8,
    parameter int DW = 8
) (
    input  logic [DW:0]   part,
    input  logic [QW-1:0] qsh,
    input  logic [DW-1:0] dmag,
    output logic [DW:0]   part_n,
    output logic [QW-1:0] qsh_n
);
    logic [DW:0] shifted;
    logic [DW:0] dext;
    logic        fits;

    always_comb begin
        shifted = {part[DW-1:0], qsh[QW-1]};
        dext    = {1'b0, dmag};
        fits    = (shifted >= dext);
        part_n  = fits ? (shifted - dext) : shifted;
        qsh_n   = {qsh[QW-2:0], fits};
    end
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
    parameter int QW = 8,
    parameter int DW = 8,
    parameter int RW = 9
) (
    input  logic [QW-1:0] qmag,
    input  logic [DW-1:0] rmag,
    input  logic          neg_a,
    input  logic          neg_b,
    input  logic          flr,
    input  logic          zero,
    input  logic [RW-1:0] a_ext,
    input  logic [RW-1:0] b_ext,
    output logic [RW-1:0] quo,
    output logic [RW-1:0] rem
);
    logic [RW-1:0] qm_x, rm_x, q_t, r_t;
    logic          adj;

    always_comb begin
        qm_x = RW'(qmag);
        rm_x = RW'(rmag);
        q_t  = (neg_a ^ neg_b) ? (~qm_x + RW'(1)) : qm_x;
        r_t  = neg_a ? (~rm_x + RW'(1)) : rm_x;
        adj  = flr && (neg_a ^ neg_b) && (rmag != '0);
        if (zero) begin
            quo = '1;
            rem = a_ext;
        end else begin
            quo = adj ? (q_t - RW'(1)) : q_t;
            rem = adj ? (r_t + b_ext) : r_t;
        end
    end
endmodule

// File: rtl/dualround_divider.sv
module dualround_divider
    import div_pkg::*;
#(
    parameter int DVD_W = 8,
    parameter int DVS_W = 8,
    parameter int RES_W = ((DVD_W > DVS_W) ? DVD_W : DVS_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             floor_mode,
    input  logic             dvd_signed,
    input  logic             dvs_signed,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             div_zero,
    output logic [RES_W-1:0] quotient,
    output logic [RES_W-1:0] remainder
);
    localparam int CNT_W = $clog2(DVD_W + 1);
    localparam int PW    = DVS_W + 1;
    localparam int AX    = RES_W - DVD_W;
    localparam int BX    = RES_W - DVS_W;

    typedef struct packed {
        div_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    part;
        logic [DVD_W-1:0] qsh;
        logic [DVS_W-1:0] dmag;
        logic             neg_a;
        logic             neg_b;
        logic             flr;
        logic             zero;
        logic [RES_W-1:0] a_ext;
        logic [RES_W-1:0] b_ext;
        logic             done;
        logic             err;
        logic [RES_W-1:0] quo;
        logic [RES_W-1:0] rem;
    } div_regs_t;

    div_regs_t r_d, r_q;

    logic             a_neg, b_neg;
    logic [DVD_W-1:0] a_mag;
    logic [DVS_W-1:0] b_mag;
    logic [PW-1:0]    step_part;
    logic [DVD_W-1:0] step_q;
    logic [RES_W-1:0] fix_quo, fix_rem;

    div_operand_prep #(.W(DVD_W)) u_prep_a (
        .val(dividend), .is_signed(dvd_signed), .neg(a_neg), .mag(a_mag)
    );

    div_operand_prep #(.W(DVS_W)) u_prep_b (
        .val(divisor), .is_signed(dvs_signed), .neg(b_neg), .mag(b_mag)
    );

    div_restore_step #(.QW(DVD_W), .DW(DVS_W)) u_step (
        .part(r_q.part), .qsh(r_q.qsh), .dmag(r_q.dmag),
        .part_n(step_part), .qsh_n(step_q)
    );

    div_sign_fix #(.QW(DVD_W), .DW(DVS_W), .RW(RES_W)) u_fix (
        .qmag(r_q.qsh), .rmag(r_q.part[DVS_W-1:0]),
        .neg_a(r_q.neg_a), .neg_b(r_q.neg_b), .flr(r_q.flr), .zero(r_q.zero),
        .a_ext(r_q.a_ext), .b_ext(r_q.b_ext),
        .quo(fix_quo), .rem(fix_rem)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_RUN;
                    r_d.cnt   = CNT_W'(DVD_W);
                    r_d.part  = '0;
                    r_d.qsh   = a_mag;
                    r_d.dmag  = b_mag;
                    r_d.neg_a = a_neg;
                    r_d.neg_b = b_neg;
                    r_d.flr   = floor_mode;
                    r_d.zero  = (divisor == '0);
                    r_d.a_ext = {{AX{dvd_signed & dividend[DVD_W-1]}}, dividend};
                    r_d.b_ext = {{BX{dvs_signed & divisor[DVS_W-1]}}, divisor};
                end
            end
            ST_RUN: begin
                r_d.part = step_part;
                r_d.qsh  = step_q;
                r_d.cnt  = r_q.cnt - CNT_W'(1);
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.st = ST_FIX;
                end
            end
            ST_FIX: begin
                r_d.quo  = fix_quo;
                r_d.rem  = fix_rem;
                r_d.err  = r_q.zero;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign div_zero  = r_q.err;
    assign quotient  = r_q.quo;
    assign remainder = r_q.rem;

endmodule

// File: rtl/dualround_divider_chk.sv
module dualround_divider_chk #(
    parameter int DVD_W = 8,
    parameter int DVS_W = 8,
    parameter int RES_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             floor_mode,
    input logic             dvd_signed,
    input logic             dvs_signed,
    input logic [DVD_W-1:0] dividend,
    input logic [DVS_W-1:0] divisor,
    input logic             busy,
    input logic             done,
    input logic             div_zero,
    input logic [RES_W-1:0] quotient,
    input logic [RES_W-1:0] remainder
);
    localparam int CW = $clog2(DVD_W + 3) + 1;

    logic          active;
    logic [CW-1:0] since;
    logic          c_flr, c_aneg, c_bneg, c_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            since  <= '0;
            c_flr  <= 1'b0;
            c_aneg <= 1'b0;
            c_bneg <= 1'b0;
            c_zero <= 1'b0;
        end else if (start && !busy) begin
            active <= 1'b1;
            since  <= '0;
            c_flr  <= floor_mode;
            c_aneg <= dvd_signed & dividend[DVD_W-1];
            c_bneg <= dvs_signed & divisor[DVS_W-1];
            c_zero <= (divisor == '0);
        end else if (active) begin
            since <= since + CW'(1);
            if (done) active <= 1'b0;
        end
    end

    assert_trunc_rem_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !c_flr && remainder != '0) |-> (remainder[RES_W-1] == c_aneg));

    assert_floor_rem_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && c_flr && remainder != '0) |-> (remainder[RES_W-1] == c_bneg));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_zero == c_zero));

    assert_zero_quotient_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (&quotient));

    assert_accept_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (active && since == CW'(DVD_W + 1)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

endmodule

bind dualround_divider dualround_divider_chk #(
    .DVD_W(DVD_W), .DVS_W(DVS_W), .RES_W(RES_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .floor_mode(floor_mode),
    .dvd_signed(dvd_signed), .dvs_signed(dvs_signed),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_zero(div_zero),
    .quotient(quotient), .remainder(remainder)
);

// File: tb/dualround_divider_test.sv
module dualround_divider_test;
    localparam int DVD_W = 8;
    localparam int DVS_W = 8;
    localparam int RES_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             floor_mode = 1'b0;
    logic             dvd_signed = 1'b0;
    logic             dvs_signed = 1'b0;
    logic [DVD_W-1:0] dividend = '0;
    logic [DVS_W-1:0] divisor = '0;
    logic             busy, done, div_zero;
    logic [RES_W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit live = 1'b0;

    always #10 clk = ~clk;

    dualround_divider #(.DVD_W(DVD_W), .DVS_W(DVS_W), .RES_W(RES_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .floor_mode(floor_mode),
        .dvd_signed(dvd_signed), .dvs_signed(dvs_signed),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .div_zero(div_zero),
        .quotient(quotient), .remainder(remainder)
    );

    function automatic void ref_div(input longint a, input longint b, input bit flr,
                                    output longint q, output longint r);
        if (b == 0) begin
            q = -1;
            r = a;
        end else begin
            q = a / b;
            r = a % b;
            if (flr && r != 0 && ((r < 0) != (b < 0))) begin
                q = q - 1;
                r = r + b;
            end
        end
    endfunction

    // behavioural cycle model
    bit               m_busy = 0, m_done = 0, m_err = 0;
    int               m_left = 0;
    logic [RES_W-1:0] m_quo = '0, m_rem = '0;
    logic [RES_W-1:0] p_quo, p_rem;
    bit               p_err;
    string            m_tag = "R8", p_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_err <= 0; m_left <= 0;
            m_quo <= '0; m_rem <= '0;
        end else begin
            m_done <= 0;
            if (!m_busy && start) begin
                longint a, b, q, r;
                a = dvd_signed ? longint'($signed(dividend)) : longint'(dividend);
                b = dvs_signed ? longint'($signed(divisor)) : longint'(divisor);
                ref_div(a, b, floor_mode, q, r);
                p_quo  <= RES_W'(q);
                p_rem  <= RES_W'(r);
                p_err  <= (b == 0);
                m_busy <= 1;
                m_left <= DVD_W + 1;
            end else if (m_busy) begin
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_busy <= 0;
                    m_done <= 1;
                    m_quo  <= p_quo;
                    m_rem  <= p_rem;
                    m_err  <= p_err;
                    m_tag  <= p_tag;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-clock comparison (R6/R7 timing, values under the operation's tag)
    always @(negedge clk) begin
        if (live) begin
            chk(busy == m_busy, "R6", "busy", busy, m_busy);
            chk(done == m_done, "R7", "done", done, m_done);
            chk(div_zero == m_err, "R5", "div_zero", div_zero, m_err);
            chk(quotient == m_quo, m_tag, "quotient", quotient, m_quo);
            chk(remainder == m_rem, m_tag, "remainder", remainder, m_rem);
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", cycles, 100000);
            summary();
        end
    end

    // drive at a negedge; returns at the negedge where done is expected high
    task automatic op(input logic [DVD_W-1:0] a, input logic [DVS_W-1:0] b,
                      input bit sa, input bit sb, input bit flr, input string tag);
        p_tag      = tag;
        dividend   = a;
        divisor    = b;
        dvd_signed = sa;
        dvs_signed = sb;
        floor_mode = flr;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (DVD_W + 1) @(negedge clk);
    endtask

    task automatic expect_res(input longint q, input longint r, input string tag);
        chk(done == 1'b1, "R7", "done at expected cycle", done, 1);
        chk(quotient == RES_W'(q), tag, "quotient", $signed(quotient), q);
        chk(remainder == RES_W'(r), tag, "remainder", $signed(remainder), r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(busy == 0 && done == 0 && div_zero == 0, "R8", "flags in reset", {busy, done, div_zero}, 0);
        chk(quotient == 0 && remainder == 0, "R8", "results in reset", quotient, 0);
        rst_n = 1'b1;
        live  = 1'b1;
        @(negedge clk);

        // R3 worked pairs, both modes
        op(-8'sd10, 8'sd3, 1, 1, 0, "R3");  expect_res(-3, -1, "R3");
        op(-8'sd10, 8'sd3, 1, 1, 1, "R3");  expect_res(-4, 2, "R3");
        op(8'sd10, -8'sd3, 1, 1, 0, "R3");  expect_res(-3, 1, "R3");
        op(8'sd10, -8'sd3, 1, 1, 1, "R3");  expect_res(-4, -2, "R3");
        op(-8'sd10, -8'sd3, 1, 1, 0, "R3"); expect_res(3, -1, "R3");
        op(-8'sd10, -8'sd3, 1, 1, 1, "R3"); expect_res(3, -1, "R3");
        op(8'sd10, 8'sd3, 1, 1, 0, "R3");   expect_res(3, 1, "R3");
        op(8'sd10, 8'sd3, 1, 1, 1, "R3");   expect_res(3, 1, "R3");

        // R1 / R2 further signed cases
        op(8'sd7, -8'sd2, 1, 1, 0, "R1");   expect_res(-3, 1, "R1");
        op(8'sd7, -8'sd2, 1, 1, 1, "R2");   expect_res(-4, -1, "R2");
        op(-8'sd9, 8'sd3, 1, 1, 1, "R2");   expect_res(-3, 0, "R2");

        // R4: signedness reinterpretation of the same bits
        op(8'hF6, 8'd3, 0, 1, 0, "R4");     expect_res(82, 0, "R4");
        op(8'hF6, 8'd3, 1, 1, 0, "R4");     expect_res(-3, -1, "R4");
        op(8'd200, 8'hFD, 0, 0, 0, "R4");   expect_res(0, 200, "R4");
        op(8'd200, 8'hFD, 0, 1, 1, "R4");   expect_res(-67, -1, "R4");
        op(8'd255, 8'd1, 0, 0, 0, "R4");    expect_res(255, 0, "R4");

        // R9: most negative by -1
        op(8'h80, 8'hFF, 1, 1, 0, "R9");    expect_res(128, 0, "R9");
        op(8'h80, 8'hFF, 1, 1, 1, "R9");    expect_res(128, 0, "R9");

        // R5: divide by zero
        op(8'hF6, 8'd0, 1, 0, 1, "R5");
        expect_res(-1, -10, "R5");
        chk(div_zero == 1'b1, "R5", "div_zero flag", div_zero, 1);
        op(8'hF6, 8'd0, 0, 1, 0, "R5");
        expect_res(-1, 246, "R5");

        // R6: start pulse while busy is ignored
        p_tag      = "R6";
        dividend   = 8'd100; divisor = 8'd7;
        dvd_signed = 0; dvs_signed = 0; floor_mode = 0;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        dividend = 8'd3; divisor = 8'd0; dvd_signed = 1; floor_mode = 1;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (DVD_W - 2) @(negedge clk);
        expect_res(14, 2, "R6");
        chk(div_zero == 1'b0, "R6", "ignored zero divisor", div_zero, 0);
        // launch in the done cycle (idle again)
        op(8'd50, 8'd6, 0, 0, 0, "R6");     expect_res(8, 2, "R6");
        op(8'd51, 8'd6, 0, 0, 1, "R6");     expect_res(8, 3, "R6");

        // R1/R2 randomized, compared every clock by the model
        for (int i = 0; i < 300; i++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            if (i % 23 == 0) b = 8'd0;
            if (i % 17 == 0) a = 8'h80;
            op(a, b, 1'($urandom), 1'($urandom), 1'(i & 1), (i & 1) ? "R2" : "R1");
        end

        // R8: outputs held after the last operation
        repeat (4) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8", "idle after run", {busy, done}, 0);
        live = 1'b0;
        summary();
    end
endmodule